// File: doc/BRIEF.md
# Multi-drop serial receiver with address-frame filtering

This block receives asynchronous serial frames on a bus shared by several nodes. The frames have one start bit, 5 to 9 data bits sent least significant bit first, and one stop bit. Each received frame carries a type bit. In 9-bit mode the type bit is the top data bit. In shorter modes the stop-bit level serves as the type bit. A type bit of one marks an address frame and a type bit of zero marks a data frame.

When the filter input is high, data frames are discarded and only address frames reach the holding register. Host software reads each address word. When a word matches the node's own address, the host clears the filter, and the data frames that follow are then delivered. A node that was not addressed keeps the filter set and ignores traffic until the next address frame.

The line is sampled with a 16x oversampling tick supplied from outside the block. The received word is held in a single register with a valid flag and an overrun flag until the host acknowledges it.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, rx_valid_o, overrun_o, frame_err_o and rx_type_o are 0 and rx_data_o is all zeros.
- R2: A frame starts only when a high-to-low transition of the line is seen on a tick and the line is still low 8 ticks later. A shorter low pulse returns the receiver to idle and delivers nothing.
- R3: data_len_i selects 5 to 9 data bits, taken least significant bit first. Bit i of the frame appears in rx_data_o[i], and unused upper bits read 0.
- R4: In 9-bit mode the type bit is data bit 8, and it is reported both on rx_type_o and in rx_data_o[8]. In 5 to 8 bit mode the type bit is the level sampled in the stop-bit position.
- R5: A low stop bit sets frame_err_o together with the stored word. In 5 to 8 bit mode such a frame has type 0.
- R6: With the filter off, every frame is stored, whatever its type.
- R7: With the filter on, a frame of type 0 leaves rx_valid_o, rx_data_o and rx_type_o unchanged.
- R8: With the filter on, a frame of type 1 is stored with rx_type_o = 1.
- R9: The filter level at the confirmation of a frame's start bit governs that whole frame. A change made later in the frame takes effect from the next frame.
- R10: rx_valid_o stays high after a stored frame until a one-cycle pulse on rd_i clears it. The same pulse clears overrun_o.
- R11: A frame that is stored while rx_valid_o is already high sets overrun_o and replaces the held word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | One-cycle pulse at 16x the bit rate |
| data_len_i | input | 4 | Number of data bits, 5 to 9 |
| filt_en_i | input | 1 | 1 = store address frames only |
| rd_i | input | 1 | Host acknowledge of the held word |
| rx_data_o | output | 9 | Held received word |
| rx_type_o | output | 1 | Type bit of the held word (1 = address) |
| rx_valid_o | output | 1 | Held word is unread |
| frame_err_o | output | 1 | Held word had a low stop bit |
| overrun_o | output | 1 | A stored frame replaced an unread word |

## Verification
A frame's outcome is decided at the middle of its stop bit, two synchronizer cycles and one tick after that point. The bench therefore drives every bit for a full 16 ticks and examines the outputs only after the whole stop bit and a short idle gap, at a falling clock edge, when the decision is certainly made and nothing can still move. The effect of an rd_i pulse is due on the next clock and is checked one cycle later. For the filter-timing cases, the filter input is changed three bit times into a frame, well after start confirmation, and the check still waits for the end of that frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_DATA  = 2'd2,
    ST_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/rx_sampler.sv
module rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS      = 16,
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned LEN_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rxd_i,
  input  logic                tick_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                filt_i,
  output logic                done_o,
  output logic [MAX_BITS-1:0] word_o,
  output logic                stop_o,
  output logic                filt_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam int unsigned IDX_W = $clog2(MAX_BITS);
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVS/2 - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(OVS - 1);

  rx_state_e          state_q;
  logic [1:0]         sync_q;
  logic               rx_s, prev_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [IDX_W-1:0]   idx_q, last_idx;
  logic [LEN_W-1:0]   len_eff;

  assign rx_s = sync_q[1];

  // clamp length into the supported range
  always_comb begin
    if (len_i < LEN_W'(MIN_BITS))      len_eff = LEN_W'(MIN_BITS);
    else if (len_i > LEN_W'(MAX_BITS)) len_eff = LEN_W'(MAX_BITS);
    else                               len_eff = len_i;
    last_idx = IDX_W'(len_eff - LEN_W'(1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q  <= 2'b11;
      prev_q  <= 1'b1;
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      word_o  <= '0;
      stop_o  <= 1'b1;
      filt_o  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rxd_i};
      done_o <= 1'b0;
      if (tick_i) begin
        prev_q <= rx_s;
        unique case (state_q)
          ST_IDLE: begin
            if (prev_q && !rx_s) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == MID_CNT) begin
              cnt_q <= '0;
              if (!rx_s) begin
                state_q <= ST_DATA;
                idx_q   <= '0;
                word_o  <= '0;
                filt_o  <= filt_i;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_DATA: begin
            if (cnt_q == FULL_CNT) begin
              cnt_q         <= '0;
              word_o[idx_q] <= rx_s;
              if (idx_q >= last_idx) state_q <= ST_STOP;
              else                   idx_q   <= idx_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (cnt_q == FULL_CNT) begin
              cnt_q   <= '0;
              stop_o  <= rx_s;
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assert_done_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_glitch_abort_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick_i && cnt_q == MID_CNT && rx_s) |=> state_q == ST_IDLE);

  assert_filt_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA || state_q == ST_STOP) |=> $stable(filt_o));
endmodule

// File: rtl/rx_type_decode.sv
module rx_type_decode #(
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned LEN_W    = 4
) (
  input  logic [MAX_BITS-1:0] word_i,
  input  logic                stop_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic                type_o,
  output logic                ferr_o
);
  logic wide_mode;

  assign wide_mode = (len_i >= LEN_W'(MAX_BITS));
  // long frames carry the type in the top data bit, short ones in the stop slot
  assign type_o    = wide_mode ? word_i[MAX_BITS-1] : stop_i;
  assign ferr_o    = !stop_i;
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int unsigned MAX_BITS = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                done_i,
  input  logic [MAX_BITS-1:0] word_i,
  input  logic                type_i,
  input  logic                ferr_i,
  input  logic                filt_i,
  input  logic                rd_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                type_o,
  output logic                valid_o,
  output logic                ferr_o,
  output logic                ovr_o
);
  logic accept;

  assign accept = done_i && (!filt_i || type_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o  <= '0;
      type_o  <= 1'b0;
      valid_o <= 1'b0;
      ferr_o  <= 1'b0;
      ovr_o   <= 1'b0;
    end else if (accept) begin
      data_o  <= word_i;
      type_o  <= type_i;
      ferr_o  <= ferr_i;
      valid_o <= 1'b1;
      ovr_o   <= (valid_o && !rd_i) || (ovr_o && !rd_i);
    end else if (rd_i) begin
      valid_o <= 1'b0;
      ovr_o   <= 1'b0;
    end
  end

  assert_drop_data_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && filt_i && !type_i && !rd_i) |=> ($stable(valid_o) && $stable(data_o) && $stable(type_o)));

  assert_addr_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && type_i) |=> (valid_o && type_o));

  assert_overrun_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_o) |-> $past(valid_o));

  assert_valid_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !rd_i) |=> valid_o);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int unsigned OVS      = 16,
  parameter int unsigned MAX_BITS = 9,
  parameter int unsigned LEN_W    = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rxd_i,
  input  logic                tick_i,
  input  logic [LEN_W-1:0]    data_len_i,
  input  logic                filt_en_i,
  input  logic                rd_i,
  output logic [MAX_BITS-1:0] rx_data_o,
  output logic                rx_type_o,
  output logic                rx_valid_o,
  output logic                frame_err_o,
  output logic                overrun_o
);
  logic                done;
  logic [MAX_BITS-1:0] word;
  logic                stop_bit;
  logic                filt_frame;
  logic                ftype;
  logic                ferr;

  rx_sampler #(.OVS(OVS), .MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_sampler (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rxd_i  (rxd_i),
    .tick_i (tick_i),
    .len_i  (data_len_i),
    .filt_i (filt_en_i),
    .done_o (done),
    .word_o (word),
    .stop_o (stop_bit),
    .filt_o (filt_frame)
  );

  rx_type_decode #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_decode (
    .word_i (word),
    .stop_i (stop_bit),
    .len_i  (data_len_i),
    .type_o (ftype),
    .ferr_o (ferr)
  );

  rx_hold_buf #(.MAX_BITS(MAX_BITS)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .done_i  (done),
    .word_i  (word),
    .type_i  (ftype),
    .ferr_i  (ferr),
    .filt_i  (filt_frame),
    .rd_i    (rd_i),
    .data_o  (rx_data_o),
    .type_o  (rx_type_o),
    .valid_o (rx_valid_o),
    .ferr_o  (frame_err_o),
    .ovr_o   (overrun_o)
  );

  assert_ferr_short_type_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && frame_err_o && data_len_i < 4'd9) |-> !rx_type_o);
endmodule

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
  localparam int BIT_CLKS = 64;  // 16 ticks of 4 clocks

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic [3:0] len = 4'd8;
  logic       filt = 1'b0;
  logic       rd = 1'b0;
  logic [8:0] rx_data;
  logic       rx_type, rx_valid, ferr, ovr;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  uart_addr_rx dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .rxd_i       (rxd),
    .tick_i      (tick),
    .data_len_i  (len),
    .filt_en_i   (filt),
    .rd_i        (rd),
    .rx_data_o   (rx_data),
    .rx_type_o   (rx_type),
    .rx_valid_o  (rx_valid),
    .frame_err_o (ferr),
    .overrun_o   (ovr)
  );

  initial begin
    forever begin
      repeat (3) @(negedge clk) tick = 1'b0;
      @(negedge clk) tick = 1'b1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int n, input logic [8:0] val, input logic stop);
    @(negedge clk) rxd = 1'b0;
    repeat (BIT_CLKS) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      rxd = val[i];
      repeat (BIT_CLKS) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT_CLKS) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS/4) @(negedge clk);
  endtask

  task automatic host_read();
    @(negedge clk) rd = 1'b1;
    @(negedge clk) rd = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check("R1 valid", rx_valid, 0);
    check("R1 overrun", ovr, 0);
    check("R1 ferr", ferr, 0);
    check("R1 type", rx_type, 0);
    check("R1 data", rx_data, 0);
    repeat (BIT_CLKS) @(negedge clk);

    // sweep: length x pattern x filter x type
    for (int n = 5; n <= 9; n++) begin
      for (int p = 0; p < 4; p++) begin
        for (int f = 0; f < 2; f++) begin
          for (int t = 0; t < 2; t++) begin
            logic [8:0] mask, val, expw;
            logic stop, etype, deliv;
            mask = 9'((10'h1 << n) - 1);
            case (p)
              0: val = 9'h000;
              1: val = 9'h1FF;
              2: val = 9'h0AA;
              default: val = 9'((n * 37 + 11) & 8'hFF);
            endcase
            if (n == 9) begin
              val[8] = t[0];
              stop = 1'b1;
              etype = t[0];
            end else begin
              stop = t[0];
              etype = t[0];
            end
            expw = val & mask;
            deliv = (f == 0) || etype;
            len = 4'(n);
            filt = f[0];
            send_frame(n, val, stop);
            if (deliv) begin
              check("R6/R8 valid stored", rx_valid, 1);
              check("R3 data", rx_data, expw);
              check("R4 type", rx_type, etype);
              check("R5 ferr", ferr, !stop);
              host_read();
              check("R10 rd clears valid", rx_valid, 0);
            end else begin
              check("R7 dropped frame", rx_valid, 0);
            end
          end
        end
      end
    end

    // R2: short low pulse is not a start bit
    len = 4'd8; filt = 1'b0;
    @(negedge clk) rxd = 1'b0;
    repeat (12) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLKS * 12) @(negedge clk);
    check("R2 glitch ignored", rx_valid, 0);
    send_frame(8, 9'h03C, 1'b1);
    check("R2 next frame valid", rx_valid, 1);
    check("R2 next frame data", rx_data, 9'h03C);
    host_read();

    // R7: held word untouched by a dropped frame
    send_frame(8, 9'h0C3, 1'b1);
    filt = 1'b1;
    send_frame(9, 9'h011, 1'b1);
    check("R7 held data unchanged", rx_data, 9'h0C3);
    check("R7 held type unchanged", rx_type, 1);
    check("R7 no overrun", ovr, 0);
    host_read();

    // R8 address handshake scenario in 9-bit mode
    len = 4'd9; filt = 1'b1;
    send_frame(9, 9'h044, 1'b1);
    check("R7 data frame dropped", rx_valid, 0);
    send_frame(9, 9'h105, 1'b1);
    check("R8 address valid", rx_valid, 1);
    check("R8 address word", rx_data, 9'h105);
    check("R8 address type", rx_type, 1);
    host_read();
    filt = 1'b0;
    send_frame(9, 9'h033, 1'b1);
    check("R6 data after unfilter", rx_valid, 1);
    check("R6 data word", rx_data, 9'h033);
    check("R4 type zero", rx_type, 0);
    host_read();

    // R9: filter change mid-frame applies from the next frame
    filt = 1'b1;
    fork
      send_frame(9, 9'h022, 1'b1);
      begin repeat (BIT_CLKS * 3) @(negedge clk); filt = 1'b0; end
    join
    check("R9 late clear still drops", rx_valid, 0);
    send_frame(9, 9'h023, 1'b1);
    check("R9 next frame delivered", rx_valid, 1);
    check("R9 next frame data", rx_data, 9'h023);
    host_read();
    fork
      send_frame(9, 9'h024, 1'b1);
      begin repeat (BIT_CLKS * 3) @(negedge clk); filt = 1'b1; end
    join
    check("R9 late set still delivers", rx_valid, 1);
    check("R9 late set data", rx_data, 9'h024);
    host_read();
    filt = 1'b0;

    // R5: framing error in 9-bit mode keeps the data-bit type
    send_frame(9, 9'h1F0, 1'b0);
    check("R5 ferr 9-bit", ferr, 1);
    check("R5 type 9-bit", rx_type, 1);
    host_read();

    // R11 overrun
    len = 4'd8;
    send_frame(8, 9'h0A1, 1'b1);
    check("R11 no overrun yet", ovr, 0);
    send_frame(8, 9'h0B2, 1'b1);
    check("R11 overrun set", ovr, 1);
    check("R11 word replaced", rx_data, 9'h0B2);
    host_read();
    check("R10 overrun cleared", ovr, 0);
    check("R10 valid cleared", rx_valid, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule